// File: doc/BRIEF.md
# Audio Packet Block-Count Sequencer

This block decides how many audio data blocks (one block per sample frame) go into each isochronous packet sent on a bus that runs at 8000 cycles per second. Once per bus cycle the packet builder pulses `advance`. In that same cycle the sequencer answers with the block count for the packet being built. The count depends on the sample-rate code and on the transmission mode. Both are captured when the stream starts.

There are two transmission modes. In blocking mode, every packet carries a fixed group of blocks, or no blocks at all when the timestamp generator reports that no timestamp is available for that cycle. In non-blocking mode, a packet carries the cycle's share of the sample rate. Rates that divide evenly into 8000 get a constant count. The 44.1 kHz family does not divide evenly. For those rates a phase counter walks a fixed pattern, and that pattern has two properties:
- over one period of the pattern, the total number of blocks exactly matches the sample rate;
- each packet whose count is rounded up comes as early as possible, which protects the receiver's buffer from running dry.

Top module: `blk_count_seq`

## Requirements
- R1: After reset and before the first `start`, `countValid` and `blockCount` both stay 0, even when `advance` is pulsed.
- R2: `rateCode` uses this encoding: 0 = 32 kHz, 1 = 44.1 kHz, 2 = 48 kHz, 3 = 88.2 kHz, 4 = 96 kHz, 5 = 176.4 kHz, 6 = 192 kHz. In blocking mode with `tsInvalid` low, the count is 8 for codes 0 to 2, 16 for codes 3 and 4, and 32 for codes 5 and 6.
- R3: In blocking mode, the count is 0 for a packet whose `tsInvalid` is high.
- R4: In non-blocking mode, the count is always 4, 6, 12 or 24 for 32, 48, 96 or 192 kHz.
- R5: In non-blocking mode at 44.1 kHz, packet n of the pattern (n = 0..79) carries ceil((n+1)·44100/8000) − ceil(n·44100/8000) blocks, giving 6 6 5 6 5 …. After packet 79 the pattern starts again at n = 0.
- R6: In non-blocking mode, 88.2 kHz carries 12 blocks at phase 0 and 11 blocks otherwise, with a period of 40 packets. 176.4 kHz carries 23 blocks at phase 0 and 22 blocks otherwise, with a period of 20 packets.
- R7: Each `start` puts the phase back to 0, so the first packet after any start, including a restart in the middle of a pattern, is packet 0.
- R8: The phase moves on only in reported packets. Cycles where `advance` is low leave the sequence unchanged.
- R9: `rateCode` and `blockMode` are taken only in the `start` cycle. While the stream runs, changes to them have no effect on the counts.
- R10: In non-blocking mode, `tsInvalid` has no effect on the count.
- R11: Rate code 7 is reserved and yields a count of 0 in both modes.
- R12: `countValid` is high exactly in cycles where `advance` is high, the stream was started at an earlier edge, and `start` is low. In all other cycles `blockCount` is 0. The output path is combinational, so the count belongs to the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts or restarts the stream: captures the configuration and clears the phase |
| advance | input | 1 | One pulse per bus cycle, meaning one packet is being built |
| rateCode | input | 3 | Sample-rate code (encoding in R2) |
| blockMode | input | 1 | 1 = blocking mode, 0 = non-blocking mode |
| tsInvalid | input | 1 | The timestamp for this packet is the no-information value |
| blockCount | output | 6 | Data blocks in the current packet |
| countValid | output | 1 | `blockCount` belongs to a packet in this cycle |

## Verification
The checks inside the design assume the following about the inputs:
- `start` and `advance` are single-cycle, synchronous pulses;
- `rateCode` and `tsInvalid` are at legal levels whenever a strobe is sampled;
- the stable-configuration check assumes that only `start` can reload the configuration.

The stimulus drives every input on the falling edge. It pulses `start` alone, except in one deliberate test where `start` and `advance` are high together. It changes the configuration while the stream runs only to show that the change is ignored. The sweep covers every rate code in both modes. In the fractional modes it runs two full 80-packet periods, so that every phase value and every wrap is visited.

// File: rtl/blk_count_pkg.sv
package blk_count_pkg;

  // Width of the count output: holds values up to 32.
  localparam int COUNT_W = 6;
  // Longest fractional pattern, in packets (44.1 kHz).
  localparam int PHASE_LEN = 80;
  localparam int PHASE_W = $clog2(PHASE_LEN);
  localparam int PHASE_HALF = PHASE_LEN / 2;

  typedef enum logic [2:0] {
    RATE_32K   = 3'd0,
    RATE_44K1  = 3'd1,
    RATE_48K   = 3'd2,
    RATE_88K2  = 3'd3,
    RATE_96K   = 3'd4,
    RATE_176K4 = 3'd5,
    RATE_192K  = 3'd6,
    RATE_RSVD  = 3'd7
  } rateSel_e;

  typedef struct packed {
    logic load;    // clear phase, new configuration taking effect
    logic report;  // a packet count is presented this cycle
    logic step;    // phase moves to the next pattern position
  } seqStrobes_t;

  // True for the rates whose per-cycle share is fractional.
  function automatic logic isFracRate(rateSel_e r);
    return (r == RATE_44K1) || (r == RATE_88K2) || (r == RATE_176K4);
  endfunction

endpackage

// File: rtl/blk_count_ctrl.sv
module blk_count_ctrl
  import blk_count_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        advance,
  input  logic [2:0]  rateCode,
  input  logic        blockMode,
  output seqStrobes_t strobes,
  output rateSel_e    cfgRate,
  output logic        cfgBlocking
);

  logic runningQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runningQ    <= 1'b0;
      cfgRate     <= RATE_32K;
      cfgBlocking <= 1'b0;
    end else if (start) begin
      runningQ    <= 1'b1;
      cfgRate     <= rateSel_e'(rateCode);
      cfgBlocking <= blockMode;
    end
  end

  always_comb begin
    strobes.load   = start;
    strobes.report = advance && runningQ && !start;
    strobes.step   = strobes.report && isFracRate(cfgRate) && !cfgBlocking;
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runningQ && !start) |=> ($stable(cfgRate) && $stable(cfgBlocking)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runningQ |-> !strobes.report);

endmodule

// File: rtl/blk_count_dp.sv
module blk_count_dp
  import blk_count_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobes_t        strobes,
  input  rateSel_e           cfgRate,
  input  logic               cfgBlocking,
  input  logic               tsInvalid,
  output logic [COUNT_W-1:0] blockCount,
  output logic               countValid
);

  localparam logic [PHASE_W-1:0] LAST_44 = PHASE_W'(PHASE_LEN - 1);
  localparam logic [PHASE_W-1:0] LAST_88 = PHASE_W'(PHASE_LEN / 2 - 1);
  localparam logic [PHASE_W-1:0] LAST_176 = PHASE_W'(PHASE_LEN / 4 - 1);
  localparam logic [PHASE_W-1:0] HALF = PHASE_W'(PHASE_HALF);

  logic [PHASE_W-1:0] phaseQ;
  logic [PHASE_W-1:0] phaseLast;
  logic [COUNT_W-1:0] rawCount;
  logic               phaseZero;
  logic               frac44Bit;

  always_comb begin
    case (cfgRate)
      RATE_88K2:  phaseLast = LAST_88;
      RATE_176K4: phaseLast = LAST_176;
      default:    phaseLast = LAST_44;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.load) begin
      phaseQ <= '0;
    end else if (strobes.step) begin
      phaseQ <= (phaseQ >= phaseLast) ? '0 : phaseQ + 1'b1;
    end
  end

  assign phaseZero = (phaseQ == '0);
  assign frac44Bit = phaseQ[0] ^ (phaseZero || (phaseQ >= HALF));

  always_comb begin
    rawCount = '0;
    if (cfgBlocking) begin
      case (cfgRate)
        RATE_32K, RATE_44K1, RATE_48K: rawCount = COUNT_W'(8);
        RATE_88K2, RATE_96K:           rawCount = COUNT_W'(16);
        RATE_176K4, RATE_192K:         rawCount = COUNT_W'(32);
        default:                       rawCount = '0;
      endcase
      if (tsInvalid) rawCount = '0;
    end else begin
      case (cfgRate)
        RATE_32K:   rawCount = COUNT_W'(4);
        RATE_48K:   rawCount = COUNT_W'(6);
        RATE_96K:   rawCount = COUNT_W'(12);
        RATE_192K:  rawCount = COUNT_W'(24);
        RATE_44K1:  rawCount = COUNT_W'(5) + COUNT_W'(frac44Bit);
        RATE_88K2:  rawCount = COUNT_W'(11) + COUNT_W'(phaseZero);
        RATE_176K4: rawCount = COUNT_W'(22) + COUNT_W'(phaseZero);
        default:    rawCount = '0;
      endcase
    end
  end

  assign countValid = strobes.report;
  assign blockCount = strobes.report ? rawCount : '0;

  // R5 R6
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ <= phaseLast || !isFracRate(cfgRate));

  // R7
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (phaseQ == '0));

  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.step && !strobes.load) |=> $stable(phaseQ));

  // R3
  no_info_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countValid && cfgBlocking && tsInvalid) |-> (blockCount == '0));

  // R4
  even48_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countValid && !cfgBlocking && cfgRate == RATE_48K) |-> (blockCount == COUNT_W'(6)));

endmodule

// File: rtl/blk_count_seq.sv
module blk_count_seq
  import blk_count_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               advance,
  input  logic [2:0]         rateCode,
  input  logic               blockMode,
  input  logic               tsInvalid,
  output logic [COUNT_W-1:0] blockCount,
  output logic               countValid
);

  seqStrobes_t strobes;
  rateSel_e    cfgRate;
  logic        cfgBlocking;

  blk_count_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .advance    (advance),
    .rateCode   (rateCode),
    .blockMode  (blockMode),
    .strobes    (strobes),
    .cfgRate    (cfgRate),
    .cfgBlocking(cfgBlocking)
  );

  blk_count_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cfgRate    (cfgRate),
    .cfgBlocking(cfgBlocking),
    .tsInvalid  (tsInvalid),
    .blockCount (blockCount),
    .countValid (countValid)
  );

endmodule

// File: tb/blk_count_seq_tb.sv
module blk_count_seq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       advance = 1'b0;
  logic [2:0] rateCode = 3'd0;
  logic       blockMode = 1'b0;
  logic       tsInvalid = 1'b0;
  logic [5:0] blockCount;
  logic       countValid;

  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  blk_count_seq dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .advance   (advance),
    .rateCode  (rateCode),
    .blockMode (blockMode),
    .tsInvalid (tsInvalid),
    .blockCount(blockCount),
    .countValid(countValid)
  );

  function automatic int rateHz(int code);
    case (code)
      0: return 32000;
      1: return 44100;
      2: return 48000;
      3: return 88200;
      4: return 96000;
      5: return 176400;
      6: return 192000;
      default: return 0;
    endcase
  endfunction

  // Rounded-up-early share of packet n, from cumulative ceilings.
  function automatic int expNonBlock(int code, int n);
    int m = n % 80;
    int r = rateHz(code);
    return ((m + 1) * r + 7999) / 8000 - (m * r + 7999) / 8000;
  endfunction

  function automatic int expBlock(int code, logic ts);
    if (ts || code > 6) return 0;
    if (code <= 2) return 8;
    if (code <= 4) return 16;
    return 32;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doStart(input int code, input logic blk);
    @(negedge clk);
    advance = 1'b0;
    start = 1'b1;
    rateCode = 3'(code);
    blockMode = blk;
    @(negedge clk);
    start = 1'b0;
  endtask

  // One packet strobe; checks valid and count in the strobe cycle.
  task automatic pkt(input logic ts, input int exp, input string req);
    @(negedge clk);
    advance = 1'b1;
    tsInvalid = ts;
    #1;
    check(countValid === 1'b1, req, int'(countValid), 1);
    check(blockCount === 6'(exp), req, int'(blockCount), exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      advance = 1'b0;
      #1;
      check(countValid === 1'b0 && blockCount === 6'd0, "R12", int'(blockCount), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: strobes before any start report nothing
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      advance = 1'b1;
      #1;
      check(countValid === 1'b0 && blockCount === 6'd0, "R1", int'(blockCount), 0);
    end
    idle(1);

    // R4 R5 R6: non-blocking sweep over every rate, two full periods
    for (int c = 0; c < 7; c++) begin
      doStart(c, 1'b0);
      for (int n = 0; n < 160; n++)
        pkt(1'b0, expNonBlock(c, n), (c == 1) ? "R5" : ((c == 3 || c == 5) ? "R6" : "R4"));
      idle(1);
    end

    // R2 R3: blocking mode, timestamp valid and invalid
    for (int c = 0; c < 7; c++) begin
      doStart(c, 1'b1);
      for (int n = 0; n < 12; n++) begin
        logic ts = (n % 3 == 1);
        pkt(ts, expBlock(c, ts), ts ? "R3" : "R2");
      end
      idle(1);
    end

    // R11: reserved code gives zero in both modes
    doStart(7, 1'b0);
    for (int n = 0; n < 4; n++) pkt(1'b0, 0, "R11");
    doStart(7, 1'b1);
    for (int n = 0; n < 4; n++) pkt(1'b0, 0, "R11");
    idle(1);

    // R7: restart mid-pattern begins again at packet 0
    doStart(1, 1'b0);
    for (int n = 0; n < 7; n++) pkt(1'b0, expNonBlock(1, n), "R7");
    doStart(1, 1'b0);
    for (int n = 0; n < 6; n++) pkt(1'b0, expNonBlock(1, n), "R7");
    idle(1);

    // R8: gaps between strobes do not move the sequence
    doStart(1, 1'b0);
    for (int n = 0; n < 90; n++) begin
      pkt(1'b0, expNonBlock(1, n), "R8");
      idle(n % 4);
    end

    // R9: configuration changes while running are ignored
    doStart(3, 1'b0);
    for (int n = 0; n < 5; n++) pkt(1'b0, expNonBlock(3, n), "R9");
    @(negedge clk);
    advance = 1'b0;
    rateCode = 3'd6;
    blockMode = 1'b1;
    for (int n = 5; n < 45; n++) pkt(1'b0, expNonBlock(3, n), "R9");
    idle(1);

    // R10: tsInvalid has no effect in non-blocking mode
    doStart(5, 1'b0);
    for (int n = 0; n < 40; n++) pkt(n[0], expNonBlock(5, n), "R10");
    idle(1);

    // R12: strobe in the start cycle is not reported and does not step
    @(negedge clk);
    start = 1'b1;
    advance = 1'b1;
    rateCode = 3'd1;
    blockMode = 1'b0;
    #1;
    check(countValid === 1'b0 && blockCount === 6'd0, "R12", int'(countValid), 0);
    @(negedge clk);
    start = 1'b0;
    advance = 1'b0;
    for (int n = 0; n < 4; n++) pkt(1'b0, expNonBlock(1, n), "R12");
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule